// File: doc/BRIEF.md
# Host Configuration Access Generator

This block turns host register accesses into configuration requests for the devices behind it. Software reaches it over two paths. On the port path, it loads a 32-bit address register that names a bus, device, function and dword register. It then reads or writes through a four-byte data window, and each window access becomes one configuration request. On the memory-mapped path, the target fields are taken directly from the access address. This path also reaches the extended register space of each function.

Each access is first checked against the size rules for its path and offset. A legal access is converted into byte enables and a lane-aligned data word. The target bus number is compared with the bus range that a local bridge claims. The result is one of three routes: a Type 0 request on the downstream link, a Type 1 request on the downstream link, or a request to the local bridge port. The completion is returned to the host with data realigned to the access size. An unclaimed request completes as a master abort.

Top module: `cfg_access_gen`

## Requirements
- R1: A request whose target bus is 0 is issued on the downstream port (`dn_req_valid`) with `cfg_type1` = 0.
- R2: A request to a non-zero bus that is below `sec_bus` or above `sub_bus` is issued on the downstream port with `cfg_type1` = 1.
- R3: A request to a non-zero bus in the range `sec_bus`..`sub_bus` is issued only on the local bridge port (`lb_req_valid`). Nothing appears on the downstream port, and the completion is taken from the `lb_cpl_*` inputs.
- R4: The address register is on the port path at `req_addr[2]` = 0. Its layout is: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function, bits 7:2 dword register. The remaining bits read back as 0. It accepts only dword accesses with `req_addr[1:0]` = 0. A narrower or misaligned access is answered with `rsp_err` = 1 and leaves the register unchanged.
- R5: A data-window access (port path, `req_addr[2]` = 1) made while the enable bit is clear issues no request. It completes with `rsp_err` = 0, `rsp_abort` = 0 and read data 0xFFFFFFFF.
- R6: Offsets 0..255 accept three sizes, encoded in `req_size`: 0 = byte, 1 = word, 2 = dword. The lane offset is `req_addr[1:0]` = L. The byte enables are 1<<L for a byte, 3<<L for a word, and 0xF for a dword. A word with L = 3, a dword with L ≠ 0, and `req_size` = 3 are rejected.
- R7: Lanes are little-endian. Host write byte k appears on link lane L+k of `cfg_wdata`. Read data returns link lanes L and upward in host byte 0 and upward, zero-extended above the access size.
- R8: Offsets 256..4095 are reachable only through the memory-mapped path, and only by a dword access with L = 0. The port-path register index is 6 bits, so it covers offsets 0..255 only. An extended-space access of any other size is rejected.
- R9: A completion flagged unclaimed (`*_cpl_ur`) ends as a master abort. A read returns 0xFFFFFFFF and a write returns 0. `rsp_abort` is high together with `rsp_valid` for exactly one cycle.
- R10: `req_ready` is high only when no access is in progress. Every accepted access produces exactly one `rsp_valid` pulse. An issued request holds its valid and all `cfg_*` fields stable until the selected port's ready is seen.
- R11: On the memory-mapped path, `req_addr` bits 27:20 give the bus, bits 19:15 the device, bits 14:12 the function, and bits 11:0 the byte offset. `cfg_reg` carries the offset divided by 4.
- R12: A rejected access issues no request. It completes with `rsp_err` = 1, `rsp_abort` = 0 and read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access valid |
| req_ready | output | 1 | Block idle, access accepted |
| req_path | input | 1 | 0 = port path, 1 = memory-mapped path |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Port offset (bits 2:0) or memory-mapped address |
| req_size | input | 2 | 0 byte, 1 word, 2 dword, 3 illegal |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Read data, right-aligned |
| rsp_err | output | 1 | Access rejected by size rules |
| rsp_abort | output | 1 | Master abort |
| sec_bus | input | 8 | Lowest bus claimed by local bridge |
| sub_bus | input | 8 | Highest bus claimed by local bridge |
| dn_req_valid | output | 1 | Request valid on downstream link |
| dn_req_ready | input | 1 | Downstream link takes request |
| lb_req_valid | output | 1 | Request valid on local bridge port |
| lb_req_ready | input | 1 | Local bridge takes request |
| cfg_type1 | output | 1 | Request is Type 1 |
| cfg_write | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_fn | output | 3 | Target function |
| cfg_reg | output | 10 | Target dword register index |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| dn_cpl_valid | input | 1 | Downstream completion |
| dn_cpl_ur | input | 1 | Downstream request unclaimed |
| dn_cpl_data | input | 32 | Downstream completion data |
| lb_cpl_valid | input | 1 | Local bridge completion |
| lb_cpl_ur | input | 1 | Local bridge request unclaimed |
| lb_cpl_data | input | 32 | Local bridge completion data |

## Verification
The assertions check these properties on every cycle:
- The bus number and request type of every issued request agree with the bridge range.
- At most one port is driven at a time.
- A request that is not yet taken stays stable.
- Extended-space requests carry full byte enables.
- A narrow write leaves the address register untouched.
- The abort flag lasts one cycle.
- Rejected responses carry no data.

Only the bench scenarios can show the following:
- The realigned read data and the lane placement of write data for every size and offset pair.
- The all-ones value returned by aborted and disabled reads.
- The read-back layout of the address register.

The bench shows these by sweeping all 256 bus numbers and the size-by-offset grid on both paths.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int BUS_W    = 8;
  localparam int DEV_W    = 5;
  localparam int FN_W     = 3;
  localparam int OFF_W    = 12;
  localparam int REG_W    = OFF_W - 2;
  localparam int IO_REG_W = 6;
  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int LANE_W   = $clog2(BE_W);
  localparam int MM_W     = BUS_W + DEV_W + FN_W + OFF_W;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2, SZ_BAD = 2'd3} size_e;
  typedef enum logic [1:0] {RT_TYPE0 = 2'd0, RT_TYPE1 = 2'd1, RT_LOCAL = 2'd2} route_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ISSUE = 2'd1, ST_WAIT = 2'd2} state_e;
  typedef enum logic [2:0] {ACT_ADDR_WR, ACT_ADDR_RD, ACT_REJECT, ACT_DISABLED, ACT_CFG} act_e;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_full,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                en,
  output logic [BUS_W-1:0]    bus,
  output logic [DEV_W-1:0]    dev,
  output logic [FN_W-1:0]     fn,
  output logic [IO_REG_W-1:0] dw,
  output logic [DATA_W-1:0]   rd_value
);
  localparam int BUS_LO = 16;
  localparam int DEV_LO = 11;
  localparam int FN_LO  = 8;
  localparam int DW_LO  = 2;

  logic                en_q, en_d;
  logic [BUS_W-1:0]    bus_q, bus_d;
  logic [DEV_W-1:0]    dev_q, dev_d;
  logic [FN_W-1:0]     fn_q, fn_d;
  logic [IO_REG_W-1:0] dw_q, dw_d;
  logic                load;

  assign load = wr_en && wr_full;

  always_comb begin
    en_d  = wr_data[DATA_W-1];
    bus_d = wr_data[BUS_LO +: BUS_W];
    dev_d = wr_data[DEV_LO +: DEV_W];
    fn_d  = wr_data[FN_LO +: FN_W];
    dw_d  = wr_data[DW_LO +: IO_REG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      bus_q <= '0;
      dev_q <= '0;
      fn_q  <= '0;
      dw_q  <= '0;
    end else if (load) begin
      en_q  <= en_d;
      bus_q <= bus_d;
      dev_q <= dev_d;
      fn_q  <= fn_d;
      dw_q  <= dw_d;
    end
  end

  always_comb begin
    rd_value = '0;
    rd_value[DATA_W-1]            = en_q;
    rd_value[BUS_LO +: BUS_W]     = bus_q;
    rd_value[DEV_LO +: DEV_W]     = dev_q;
    rd_value[FN_LO +: FN_W]       = fn_q;
    rd_value[DW_LO +: IO_REG_W]   = dw_q;
  end

  assign en  = en_q;
  assign bus = bus_q;
  assign dev = dev_q;
  assign fn  = fn_q;
  assign dw  = dw_q;

  // R4: a narrow or misaligned write leaves the register as it was
  p_narrow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_full |=> $stable(rd_value));
  // R4: a full write reads back with reserved bits cleared
  p_full_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_full |=> rd_value == ($past(wr_data) & 32'h80FF_FFFC));
endmodule

// File: rtl/cfg_lane_map.sv
module cfg_lane_map
  import cfg_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [LANE_W-1:0] lo,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] link_rdata,
  output logic              legal,
  output logic [BE_W-1:0]   be,
  output logic [DATA_W-1:0] link_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int CNT_W = LANE_W + 1;

  logic [CNT_W-1:0]  nbytes;
  logic [CNT_W-1:0]  start;
  logic [CNT_W-1:0]  span;
  logic [DATA_W-1:0] shifted;
  logic [BE_W-1:0]   keep;

  always_comb begin
    unique case (size_e'(size))
      SZ_BYTE:  nbytes = CNT_W'(1);
      SZ_WORD:  nbytes = CNT_W'(2);
      SZ_DWORD: nbytes = CNT_W'(BE_W);
      default:  nbytes = '0;
    endcase
  end

  assign start   = {1'b0, lo};
  assign span    = start + nbytes;
  assign legal   = (nbytes != '0) && (span <= CNT_W'(BE_W));
  assign link_wdata = host_wdata << {lo, 3'b000};
  assign shifted    = link_rdata >> {lo, 3'b000};

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign be[g]   = legal && (start <= CNT_W'(g)) && (CNT_W'(g) < span);
    assign keep[g] = CNT_W'(g) < nbytes;
    assign host_rdata[8*g +: 8] = keep[g] ? shifted[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/cfg_router.sv
module cfg_router
  import cfg_pkg::*;
(
  input  logic [BUS_W-1:0] bus,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [BUS_W-1:0] sub_bus,
  output route_e           route
);
  logic in_range;

  assign in_range = (bus >= sec_bus) && (bus <= sub_bus);

  always_comb begin
    if (bus == '0)     route = RT_TYPE0;
    else if (in_range) route = RT_LOCAL;
    else               route = RT_TYPE1;
  end
endmodule

// File: rtl/cfg_access_gen.sv
module cfg_access_gen
  import cfg_pkg::*;
#(
  parameter int EXT_OFF = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_path,
  input  logic              req_write,
  input  logic [27:0]       req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_abort,
  input  logic [7:0]        sec_bus,
  input  logic [7:0]        sub_bus,
  output logic              dn_req_valid,
  input  logic              dn_req_ready,
  output logic              lb_req_valid,
  input  logic              lb_req_ready,
  output logic              cfg_type1,
  output logic              cfg_write,
  output logic [7:0]        cfg_bus,
  output logic [4:0]        cfg_dev,
  output logic [2:0]        cfg_fn,
  output logic [9:0]        cfg_reg,
  output logic [3:0]        cfg_be,
  output logic [31:0]       cfg_wdata,
  input  logic              dn_cpl_valid,
  input  logic              dn_cpl_ur,
  input  logic [31:0]       dn_cpl_data,
  input  logic              lb_cpl_valid,
  input  logic              lb_cpl_ur,
  input  logic [31:0]       lb_cpl_data
);
  localparam int OFF_LO  = 0;
  localparam int FN_LO   = OFF_LO + OFF_W;
  localparam int DEV_LO  = FN_LO + FN_W;
  localparam int BUS_LO  = DEV_LO + DEV_W;
  localparam int EXT_IDX = EXT_OFF / 4;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  // address register
  logic                ar_en;
  logic [BUS_W-1:0]    ar_bus;
  logic [DEV_W-1:0]    ar_dev;
  logic [FN_W-1:0]     ar_fn;
  logic [IO_REG_W-1:0] ar_dw;
  logic [DATA_W-1:0]   ar_value;
  logic                ar_wr_en;
  logic                dword_aligned;

  // state
  state_e            state_q, state_d;
  logic              accept;
  act_e              act;

  // decode
  logic              io_addr_sel, io_data_sel, ext_off;
  logic [OFF_W-1:0]  mm_off;
  logic [BUS_W-1:0]  t_bus;
  logic [DEV_W-1:0]  t_dev;
  logic [FN_W-1:0]   t_fn;
  logic [REG_W-1:0]  t_reg;
  route_e            t_route;

  // lane mapping
  logic [1:0]        ln_size;
  logic [LANE_W-1:0] ln_lo;
  logic              ln_legal;
  logic [BE_W-1:0]   ln_be;
  logic [DATA_W-1:0] ln_wdata, ln_rdata, ln_link_rdata;

  // latched request
  logic              load;
  logic              type1_q, write_q, local_q;
  logic [BUS_W-1:0]  bus_q;
  logic [DEV_W-1:0]  dev_q;
  logic [FN_W-1:0]   fn_q;
  logic [REG_W-1:0]  reg_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        size_q;
  logic [LANE_W-1:0] lo_q;

  // completion and response
  logic              cpl_v, cpl_ur, sel_ready;
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_err_q, rsp_err_d;
  logic              rsp_abort_q, rsp_abort_d;
  logic [DATA_W-1:0] rsp_rdata_q, rsp_rdata_d;

  assign accept        = req_valid && (state_q == ST_IDLE);
  assign dword_aligned = (size_e'(req_size) == SZ_DWORD) && (req_addr[1:0] == 2'b00);
  assign io_addr_sel   = !req_path && !req_addr[2];
  assign io_data_sel   = !req_path && req_addr[2];
  assign mm_off        = req_addr[OFF_LO +: OFF_W];
  assign ext_off       = mm_off >= OFF_W'(EXT_OFF);
  assign ar_wr_en      = accept && io_addr_sel && req_write;

  cfg_addr_reg u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ar_wr_en),
    .wr_full  (dword_aligned),
    .wr_data  (req_wdata),
    .en       (ar_en),
    .bus      (ar_bus),
    .dev      (ar_dev),
    .fn       (ar_fn),
    .dw       (ar_dw),
    .rd_value (ar_value)
  );

  // target fields from the chosen path
  always_comb begin
    if (req_path) begin
      t_bus = req_addr[BUS_LO +: BUS_W];
      t_dev = req_addr[DEV_LO +: DEV_W];
      t_fn  = req_addr[FN_LO +: FN_W];
      t_reg = mm_off[OFF_W-1:2];
    end else begin
      t_bus = ar_bus;
      t_dev = ar_dev;
      t_fn  = ar_fn;
      t_reg = REG_W'(ar_dw);
    end
  end

  cfg_router u_route (
    .bus     (t_bus),
    .sec_bus (sec_bus),
    .sub_bus (sub_bus),
    .route   (t_route)
  );

  assign ln_size       = (state_q == ST_IDLE) ? req_size : size_q;
  assign ln_lo         = (state_q == ST_IDLE) ? req_addr[LANE_W-1:0] : lo_q;
  assign ln_link_rdata = local_q ? lb_cpl_data : dn_cpl_data;

  cfg_lane_map u_lane (
    .size       (ln_size),
    .lo         (ln_lo),
    .host_wdata (req_wdata),
    .link_rdata (ln_link_rdata),
    .legal      (ln_legal),
    .be         (ln_be),
    .link_wdata (ln_wdata),
    .host_rdata (ln_rdata)
  );

  // access classification
  always_comb begin
    if (io_addr_sel) begin
      if (!dword_aligned)  act = ACT_REJECT;
      else if (req_write)  act = ACT_ADDR_WR;
      else                 act = ACT_ADDR_RD;
    end else if (io_data_sel) begin
      if (!ln_legal)       act = ACT_REJECT;
      else if (!ar_en)     act = ACT_DISABLED;
      else                 act = ACT_CFG;
    end else begin
      if (ext_off && !dword_aligned) act = ACT_REJECT;
      else if (!ln_legal)            act = ACT_REJECT;
      else                           act = ACT_CFG;
    end
  end

  assign load      = accept && (act == ACT_CFG);
  assign sel_ready = local_q ? lb_req_ready : dn_req_ready;
  assign cpl_v     = local_q ? lb_cpl_valid : dn_cpl_valid;
  assign cpl_ur    = local_q ? lb_cpl_ur : dn_cpl_ur;

  // next state and response
  always_comb begin
    state_d     = state_q;
    rsp_valid_d = 1'b0;
    rsp_err_d   = 1'b0;
    rsp_abort_d = 1'b0;
    rsp_rdata_d = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          unique case (act)
            ACT_ADDR_WR:  rsp_valid_d = 1'b1;
            ACT_ADDR_RD:  begin rsp_valid_d = 1'b1; rsp_rdata_d = ar_value; end
            ACT_REJECT:   begin rsp_valid_d = 1'b1; rsp_err_d = 1'b1; end
            ACT_DISABLED: begin rsp_valid_d = 1'b1; rsp_rdata_d = req_write ? '0 : ALL_ONES; end
            default:      state_d = ST_ISSUE;
          endcase
        end
      end
      ST_ISSUE: if (sel_ready) state_d = ST_WAIT;
      ST_WAIT: begin
        if (cpl_v) begin
          state_d     = ST_IDLE;
          rsp_valid_d = 1'b1;
          rsp_abort_d = cpl_ur;
          if (write_q)     rsp_rdata_d = '0;
          else if (cpl_ur) rsp_rdata_d = ALL_ONES;
          else             rsp_rdata_d = ln_rdata;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_abort_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rsp_abort_q <= rsp_abort_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type1_q <= 1'b0;
      write_q <= 1'b0;
      local_q <= 1'b0;
      bus_q   <= '0;
      dev_q   <= '0;
      fn_q    <= '0;
      reg_q   <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      lo_q    <= '0;
    end else if (load) begin
      type1_q <= (t_route == RT_TYPE1);
      write_q <= req_write;
      local_q <= (t_route == RT_LOCAL);
      bus_q   <= t_bus;
      dev_q   <= t_dev;
      fn_q    <= t_fn;
      reg_q   <= t_reg;
      be_q    <= ln_be;
      wdata_q <= ln_wdata;
      size_q  <= req_size;
      lo_q    <= req_addr[LANE_W-1:0];
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign dn_req_valid = (state_q == ST_ISSUE) && !local_q;
  assign lb_req_valid = (state_q == ST_ISSUE) && local_q;
  assign cfg_type1    = type1_q;
  assign cfg_write    = write_q;
  assign cfg_bus      = bus_q;
  assign cfg_dev      = dev_q;
  assign cfg_fn       = fn_q;
  assign cfg_reg      = reg_q;
  assign cfg_be       = be_q;
  assign cfg_wdata    = wdata_q;
  assign rsp_valid    = rsp_valid_q;
  assign rsp_rdata    = rsp_rdata_q;
  assign rsp_err      = rsp_err_q;
  assign rsp_abort    = rsp_abort_q;

  p_bus0_type0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && (cfg_bus == '0) |-> !cfg_type1);
  p_outside_type1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && (cfg_bus != '0) |-> cfg_type1 && ((cfg_bus < sec_bus) || (cfg_bus > sub_bus)));
  p_local_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lb_req_valid |-> (cfg_bus != '0) && (cfg_bus >= sec_bus) && (cfg_bus <= sub_bus));
  p_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dn_req_valid, lb_req_valid}));
  p_be_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid || lb_req_valid) |-> cfg_be != '0);
  p_ext_dword_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid || lb_req_valid) && (cfg_reg >= REG_W'(EXT_IDX)) |-> cfg_be == '1);
  p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_abort |=> !rsp_abort);
  p_abort_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_abort |-> rsp_valid);
  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid || lb_req_valid) |-> !req_ready);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid &&
      $stable({cfg_type1, cfg_write, cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_be, cfg_wdata}));
  p_reject_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid && !rsp_abort && (rsp_rdata == '0));
endmodule

// File: tb/test_cfg_access_gen.sv
module test_cfg_access_gen;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_path, req_write;
  logic [27:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err, rsp_abort;
  logic [31:0] rsp_rdata;
  logic [7:0]  sec_bus, sub_bus;
  logic        dn_req_valid, dn_req_ready, lb_req_valid, lb_req_ready;
  logic        cfg_type1, cfg_write;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [9:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        dn_cpl_valid, dn_cpl_ur, lb_cpl_valid, lb_cpl_ur;
  logic [31:0] dn_cpl_data, lb_cpl_data;

  int n_checks = 0, n_fail = 0;
  int dn_cnt = 0, lb_cnt = 0;
  logic        cap_type1;
  logic [7:0]  cap_bus;
  logic [4:0]  cap_dev;
  logic [2:0]  cap_fn;
  logic [9:0]  cap_reg;
  logic [3:0]  cap_be;
  logic [31:0] cap_wdata;

  cfg_access_gen i_cfg_access_gen (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] model(input logic [7:0] b, input logic [4:0] d,
                                        input logic [2:0] f, input logic [9:0] r);
    return {b, d, f, 6'b0, r};
  endfunction

  function automatic bit lane_ok(input int sz, input int lo);
    if (sz == 0) return 1'b1;
    if (sz == 1) return lo != 3;
    if (sz == 2) return lo == 0;
    return 1'b0;
  endfunction

  function automatic logic [3:0] exp_be(input int sz, input int lo);
    if (sz == 0) return 4'(1 << lo);
    if (sz == 1) return 4'(3 << lo);
    return 4'hF;
  endfunction

  function automatic logic [31:0] size_mask(input int sz);
    if (sz == 0) return 32'h0000_00FF;
    if (sz == 1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = be[k] ? 8'hFF : 8'h00;
    return m;
  endfunction

  // link-side responder: takes every request, completes one cycle later
  always @(posedge clk) begin
    dn_cpl_valid <= 1'b0;
    lb_cpl_valid <= 1'b0;
    if (dn_req_valid && dn_req_ready) begin
      dn_cpl_valid <= 1'b1;
      dn_cpl_ur    <= (cfg_dev == 5'd31);
      dn_cpl_data  <= model(cfg_bus, cfg_dev, cfg_fn, cfg_reg);
      dn_cnt       <= dn_cnt + 1;
    end
    if (lb_req_valid && lb_req_ready) begin
      lb_cpl_valid <= 1'b1;
      lb_cpl_ur    <= (cfg_dev == 5'd31);
      lb_cpl_data  <= model(cfg_bus, cfg_dev, cfg_fn, cfg_reg);
      lb_cnt       <= lb_cnt + 1;
    end
    if ((dn_req_valid && dn_req_ready) || (lb_req_valid && lb_req_ready)) begin
      cap_type1 <= cfg_type1; cap_bus <= cfg_bus; cap_dev <= cfg_dev;
      cap_fn <= cfg_fn; cap_reg <= cfg_reg; cap_be <= cfg_be; cap_wdata <= cfg_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] r_data;
  logic        r_err, r_abort, r_abort_next, r_busy_ready;
  int          r_ndn, r_nlb;

  task automatic access(input logic path, input logic wr, input logic [27:0] addr,
                        input logic [1:0] sz, input logic [31:0] wd);
    int d0, l0, guard;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    d0 = dn_cnt; l0 = lb_cnt;
    req_valid = 1'b1; req_path = path; req_write = wr;
    req_addr = addr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    r_busy_ready = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 40) begin
      if (req_ready) r_busy_ready = 1'b1;
      @(negedge clk);
      guard++;
    end
    chk(rsp_valid, "R10 response", {31'b0, rsp_valid}, 32'd1);
    r_data = rsp_rdata; r_err = rsp_err; r_abort = rsp_abort;
    r_ndn = dn_cnt - d0; r_nlb = lb_cnt - l0;
    @(negedge clk);
    r_abort_next = rsp_abort;
  endtask

  task automatic set_addr(input logic [31:0] v);
    access(1'b0, 1'b1, 28'h0, 2'd2, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_path = 1'b0; req_write = 1'b0;
    req_addr = '0; req_size = '0; req_wdata = '0;
    sec_bus = 8'd8; sub_bus = 8'd12;
    dn_req_ready = 1'b1; lb_req_ready = 1'b1;
    dn_cpl_ur = 1'b0; lb_cpl_ur = 1'b0; dn_cpl_data = '0; lb_cpl_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !dn_req_valid && !lb_req_valid, "R10 reset idle",
        {28'b0, req_ready, rsp_valid, dn_req_valid, lb_req_valid}, 32'h8);

    // R4: address register layout and size rules
    set_addr(32'hFFFF_FFFF);
    access(1'b0, 1'b0, 28'h0, 2'd2, 32'h0);
    chk(r_data == 32'h80FF_FFFC && !r_err, "R4 readback", r_data, 32'h80FF_FFFC);
    for (int sz = 0; sz < 4; sz++) begin
      for (int lo = 0; lo < 4; lo++) begin
        if (sz == 2 && lo == 0) continue;
        access(1'b0, 1'b1, 28'(lo), 2'(sz), 32'h0000_0000);
        chk(r_err, "R4 narrow write rejected", {31'b0, r_err}, 32'd1);
        access(1'b0, 1'b0, 28'h0, 2'd2, 32'h0);
        chk(r_data == 32'h80FF_FFFC, "R4 narrow write ignored", r_data, 32'h80FF_FFFC);
      end
    end
    access(1'b0, 1'b0, 28'h1, 2'd0, 32'h0);
    chk(r_err && r_data == 0, "R4 narrow read rejected", r_data, 32'h0);

    // R5: window while disabled
    set_addr(32'h0002_1114);
    access(1'b0, 1'b0, 28'h4, 2'd2, 32'h0);
    chk(r_data == 32'hFFFF_FFFF && !r_err && !r_abort && r_ndn == 0 && r_nlb == 0,
        "R5 disabled read", r_data, 32'hFFFF_FFFF);
    access(1'b0, 1'b1, 28'h4, 2'd2, 32'h1234_5678);
    chk(r_ndn == 0 && r_nlb == 0 && !r_err, "R5 disabled write", 32'(r_ndn + r_nlb), 32'd0);

    // R6 R7 R12: window sweep, bus 0 device 2 function 1 register 5
    set_addr(32'h8000_1114);
    for (int sz = 0; sz < 4; sz++) begin
      for (int lo = 0; lo < 4; lo++) begin
        logic [31:0] m, ex;
        m = model(8'd0, 5'd2, 3'd1, 10'd5);
        access(1'b0, 1'b0, 28'(4 + lo), 2'(sz), 32'h0);
        if (lane_ok(sz, lo)) begin
          ex = (m >> (8 * lo)) & size_mask(sz);
          chk(!r_err && r_data == ex, "R7 read lanes", r_data, ex);
          chk(r_ndn == 1 && cap_be == exp_be(sz, lo) && cap_reg == 10'd5 && !cap_type1,
              "R6 byte enables", {28'b0, cap_be}, {28'b0, exp_be(sz, lo)});
        end else begin
          chk(r_err && r_data == 0 && r_ndn == 0, "R12 rejected read", r_data, 32'h0);
        end
        access(1'b0, 1'b1, 28'(4 + lo), 2'(sz), 32'h4433_2211);
        if (lane_ok(sz, lo)) begin
          ex = (32'h4433_2211 << (8 * lo)) & lane_mask(exp_be(sz, lo));
          chk(r_ndn == 1 && (cap_wdata & lane_mask(cap_be)) == ex, "R7 write lanes",
              cap_wdata & lane_mask(cap_be), ex);
        end else begin
          chk(r_err && r_ndn == 0 && r_nlb == 0, "R12 rejected write", {31'b0, r_err}, 32'd1);
        end
      end
    end

    // R1 R2 R3 R11 R10: full bus sweep on the memory-mapped path
    for (int b = 0; b < 256; b++) begin
      logic [27:0] a;
      logic [31:0] ex;
      a = {8'(b), 5'd3, 3'd2, 12'h010};
      ex = model(8'(b), 5'd3, 3'd2, 10'd4);
      access(1'b1, 1'b0, a, 2'd2, 32'h0);
      chk(r_data == ex && !r_busy_ready, "R11 fields and data", r_data, ex);
      chk(cap_bus == 8'(b) && cap_dev == 5'd3 && cap_fn == 3'd2 && cap_reg == 10'd4,
          "R11 request fields", {cap_bus, 3'b0, cap_dev, cap_fn, 3'b0, cap_reg}, {8'(b), 3'b0, 5'd3, 3'd2, 3'b0, 10'd4});
      if (b == 0)
        chk(r_ndn == 1 && r_nlb == 0 && !cap_type1, "R1 type0", {31'b0, cap_type1}, 32'd0);
      else if (b >= 8 && b <= 12)
        chk(r_ndn == 0 && r_nlb == 1, "R3 local route", 32'(r_nlb), 32'd1);
      else
        chk(r_ndn == 1 && r_nlb == 0 && cap_type1, "R2 type1", {31'b0, cap_type1}, 32'd1);
    end

    // R8: extended offsets on the memory-mapped path
    for (int oi = 0; oi < 7; oi++) begin
      int off;
      case (oi)
        0: off = 12'h0FC; 1: off = 12'h100; 2: off = 12'h101; 3: off = 12'h102;
        4: off = 12'hFFC; 5: off = 12'hFFE; default: off = 12'hFFF;
      endcase
      for (int sz = 0; sz < 4; sz++) begin
        bit legal;
        int lo;
        logic [31:0] ex;
        lo = off % 4;
        legal = (off < 256) ? lane_ok(sz, lo) : (sz == 2 && lo == 0);
        access(1'b1, 1'b0, {8'd0, 5'd1, 3'd0, 12'(off)}, 2'(sz), 32'h0);
        ex = legal ? ((model(8'd0, 5'd1, 3'd0, 10'(off / 4)) >> (8 * lo)) & size_mask(sz)) : 32'h0;
        chk(r_err == !legal && r_data == ex && r_ndn == (legal ? 1 : 0),
            "R8 extended size rule", r_data, ex);
      end
    end

    // R9: master abort on both ports
    access(1'b1, 1'b0, {8'd0, 5'd31, 3'd0, 12'h000}, 2'd0, 32'h0);
    chk(r_data == 32'hFFFF_FFFF && r_abort && !r_abort_next, "R9 abort read", r_data, 32'hFFFF_FFFF);
    access(1'b1, 1'b1, {8'd5, 5'd31, 3'd0, 12'h000}, 2'd2, 32'h1);
    chk(r_data == 0 && r_abort && !r_abort_next && r_ndn == 1, "R9 abort write", r_data, 32'h0);
    access(1'b1, 1'b0, {8'd9, 5'd31, 3'd0, 12'h000}, 2'd2, 32'h0);
    chk(r_data == 32'hFFFF_FFFF && r_abort && r_nlb == 1, "R9 abort local", r_data, 32'hFFFF_FFFF);
    access(1'b1, 1'b0, {8'd0, 5'd4, 3'd0, 12'h000}, 2'd2, 32'h0);
    chk(!r_abort && !r_err, "R9 claimed no abort", {31'b0, r_abort}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule